// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges the reset requests of a bus-attached network controller and turns them into per-domain reset outputs. Six sources feed it: power-on reset, an active-low board reset, bus power presence, a self-clearing soft-reset bit, a host bus reset and a lite-reset pulse. It drives a core-domain reset and a bus-interface-domain reset, and asks the bus side to disconnect. It starts a reload of the configuration memory, either full or address-only. It holds the PHY in power-down and reports a READY flag.

Only one source is served at a time. When sources overlap, the one with the widest scope wins. A reset that starts a reload keeps READY low until the memory reports that loading is done. If the strap says no memory is fitted, READY comes up one cycle after the core reset is released. A small control register runs through the sequencer. A mask parameter marks which of its bits survive the narrower resets.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Overlapping requests are served widest first: power loss, then board reset, then soft reset, then bus reset, then lite reset. A request narrower than the one in progress does not change the outputs.
- R2: While `vbus_i` is 0, `core_rst_o`, `bif_rst_o` and `disconnect_o` are 1 from the next cycle on. When power returns, the sequencer passes one cycle in board reset and then requests a full reload (`reload_full_o`=1).
- R3: `por_i` high asserts `core_rst_o`, `bif_rst_o`, `disconnect_o` and `phy_pd_o`, and clears `ready_o` and `cfg_q_o`. Either `por_i` high or `ext_rst_n_i` low keeps the core and bus-interface resets asserted. In the cycle after release, the core reset falls and a full reload is requested.
- R4: A soft-reset write sets `soft_bit_o` for exactly CLK_MHZ*SOFT_NS/1000 cycles (500 by default). During that time the core reset, the bus-interface reset and the disconnect request are all 1.
- R5: When `soft_bit_o` clears, the core reset falls and a full reload is requested in that same cycle.
- R6: A bus reset asserts only `core_rst_o`. `bif_rst_o` and `disconnect_o` stay 0. After `bus_rst_i` is released, an address-only reload is requested (`reload_full_o`=0).
- R7: A lite-reset pulse asserts `core_rst_o` for one cycle. It leaves `bif_rst_o`, `ready_o` and `phy_pd_o` unchanged and requests no reload.
- R8: After a reset that reloads, `ready_o` stays 0 while `reload_req_o` is 1. It becomes 1 on the cycle after `load_done_i` is sampled high.
- R9: With `mem_present_i`=0, `reload_req_o` stays 0, and `ready_o` becomes 1 one cycle after `core_rst_o` falls.
- R10: Entering a power, board, soft or bus reset sets `phy_pd_o`. Only `phy_wake_i`, sampled while the core is out of reset, clears it.
- R11: `cfg_q_o` takes `cfg_wd_i` on `cfg_we_i` only while the core is out of reset. Power loss and board reset clear every bit. Soft, bus and lite resets clear only the bits that are 0 in KEEP_MASK (default 8'hF0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| ext_rst_n_i | input | 1 | Board reset, active low |
| vbus_i | input | 1 | Bus power present |
| soft_wr_i | input | 1 | Write of 1 to the soft-reset bit |
| bus_rst_i | input | 1 | Host bus reset, held for its duration |
| lite_req_i | input | 1 | Lite-reset request pulse |
| mem_present_i | input | 1 | Strap: configuration memory fitted |
| load_done_i | input | 1 | Configuration memory load finished |
| phy_wake_i | input | 1 | Software request to leave PHY power-down |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wd_i | input | CFG_W | Control register write data |
| core_rst_o | output | 1 | Core-domain reset |
| bif_rst_o | output | 1 | Bus-interface-domain reset |
| disconnect_o | output | 1 | Bus disconnect request |
| soft_bit_o | output | 1 | Read value of the self-clearing soft-reset bit |
| reload_req_o | output | 1 | Configuration reload request |
| reload_full_o | output | 1 | 1 = full reload, 0 = address-only reload |
| phy_pd_o | output | 1 | PHY power-down request |
| ready_o | output | 1 | Device ready |
| cfg_q_o | output | CFG_W | Control register value |

## Verification
The properties assume that all request inputs and `mem_present_i` are synchronous to `clk`. They also assume that the memory strap does not change while a reload is pending, because the soft-reset completion check reads the strap in the cycle the bit clears. The bench changes every input only on the falling edge. It changes the strap only while the block is idle and READY. It always releases a request before the matching recovery starts.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_LOAD  = 3'd1,
      ST_LITE  = 3'd2,
      ST_BUS   = 3'd3,
      ST_SOFT  = 3'd4,
      ST_HARD  = 3'd5,
      ST_UNPWR = 3'd6
   } rst_st_e;

   // numeric value is the scope rank used for arbitration
   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_LITE = 3'd1,
      SRC_BUS  = 3'd2,
      SRC_SOFT = 3'd3,
      SRC_HARD = 3'd4,
      SRC_PWR  = 3'd5
   } rst_src_e;

   function automatic logic [2:0] st_rank(rst_st_e s);
      case (s)
         ST_UNPWR: return 3'd5;
         ST_HARD:  return 3'd4;
         ST_SOFT:  return 3'd3;
         ST_BUS:   return 3'd2;
         ST_LITE:  return 3'd1;
         default:  return 3'd0;
      endcase
   endfunction

   function automatic rst_st_e src_state(rst_src_e s);
      case (s)
         SRC_PWR:  return ST_UNPWR;
         SRC_HARD: return ST_HARD;
         SRC_SOFT: return ST_SOFT;
         SRC_BUS:  return ST_BUS;
         SRC_LITE: return ST_LITE;
         default:  return ST_RUN;
      endcase
   endfunction

endpackage

// File: rtl/rst_src_arb.sv
module rst_src_arb
   import rst_seq_pkg::*;
(
   input  logic     vbus_i,
   input  logic     ext_rst_n_i,
   input  logic     soft_wr_i,
   input  logic     bus_rst_i,
   input  logic     lite_req_i,
   output rst_src_e src_o
);

   always_comb begin
      if (!vbus_i)           src_o = SRC_PWR;
      else if (!ext_rst_n_i) src_o = SRC_HARD;
      else if (soft_wr_i)    src_o = SRC_SOFT;
      else if (bus_rst_i)    src_o = SRC_BUS;
      else if (lite_req_i)   src_o = SRC_LITE;
      else                   src_o = SRC_NONE;
   end

endmodule

// File: rtl/rst_soft_timer.sv
module rst_soft_timer #(
   parameter int CYC = 500
) (
   input  logic clk,
   input  logic rst_i,
   input  logic load_i,
   input  logic run_i,
   output logic zero_o
);

   generate
      if (CYC == 1) begin : g_single
         assign zero_o = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(CYC + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or posedge rst_i) begin
            if (rst_i)                       cnt_q <= '0;
            else if (load_i)                 cnt_q <= CW'(CYC - 1);
            else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
         end
         assign zero_o = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/rst_cfg_keep.sv
module rst_cfg_keep #(
   parameter int               W    = 8,
   parameter logic [W-1:0]     KEEP = '0
) (
   input  logic         clk,
   input  logic         rst_i,
   input  logic         we_i,
   input  logic [W-1:0] wd_i,
   input  logic         clr_all_i,
   input  logic         clr_part_i,
   output logic [W-1:0] q_o
);

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic bit_q;
         if (KEEP[b]) begin : g_keep
            always_ff @(posedge clk or posedge rst_i) begin
               if (rst_i)                     bit_q <= 1'b0;
               else if (clr_all_i)            bit_q <= 1'b0;
               else if (we_i && !clr_part_i)  bit_q <= wd_i[b];
            end
         end else begin : g_clear
            always_ff @(posedge clk or posedge rst_i) begin
               if (rst_i)                        bit_q <= 1'b0;
               else if (clr_all_i || clr_part_i) bit_q <= 1'b0;
               else if (we_i)                    bit_q <= wd_i[b];
            end
         end
         assign q_o[b] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
   import rst_seq_pkg::*;
#(
   parameter int               CLK_MHZ   = 250,
   parameter int               SOFT_NS   = 2000,
   parameter int               CFG_W     = 8,
   parameter logic [CFG_W-1:0] KEEP_MASK = 8'hF0
) (
   input  logic             clk,
   input  logic             por_i,
   input  logic             ext_rst_n_i,
   input  logic             vbus_i,
   input  logic             soft_wr_i,
   input  logic             bus_rst_i,
   input  logic             lite_req_i,
   input  logic             mem_present_i,
   input  logic             load_done_i,
   input  logic             phy_wake_i,
   input  logic             cfg_we_i,
   input  logic [CFG_W-1:0] cfg_wd_i,
   output logic             core_rst_o,
   output logic             bif_rst_o,
   output logic             disconnect_o,
   output logic             soft_bit_o,
   output logic             reload_req_o,
   output logic             reload_full_o,
   output logic             phy_pd_o,
   output logic             ready_o,
   output logic [CFG_W-1:0] cfg_q_o
);

   localparam int SOFT_CYC = CLK_MHZ * SOFT_NS / 1000;

   generate
      if (SOFT_CYC < 1) begin : g_chk_soft
         $error("soft reset interval rounds to zero cycles");
      end
      if (CFG_W < 1) begin : g_chk_cfg
         $error("CFG_W must be at least 1");
      end
   endgenerate

   rst_st_e  state_q, state_d;
   rst_src_e src;
   logic     tmr_zero, enter, full_q, ready_q, pd_q, core_up;
   logic [2:0] nxt_rank;

   rst_src_arb u_arb (
      .vbus_i      (vbus_i),
      .ext_rst_n_i (ext_rst_n_i),
      .soft_wr_i   (soft_wr_i),
      .bus_rst_i   (bus_rst_i),
      .lite_req_i  (lite_req_i),
      .src_o       (src)
   );

   always_comb begin
      state_d = state_q;
      if (3'(src) > st_rank(state_q)) begin
         state_d = src_state(src);
      end else begin
         case (state_q)
            ST_UNPWR: if (vbus_i)      state_d = ST_HARD;
            ST_HARD:  if (ext_rst_n_i) state_d = ST_LOAD;
            ST_SOFT:  if (tmr_zero)    state_d = ST_LOAD;
            ST_BUS:   if (!bus_rst_i)  state_d = ST_LOAD;
            ST_LITE:  state_d = ready_q ? ST_RUN : ST_LOAD;
            ST_LOAD:  if (!mem_present_i || load_done_i) state_d = ST_RUN;
            default:  state_d = ST_RUN;
         endcase
      end
   end

   assign enter    = (state_d != state_q);
   assign nxt_rank = st_rank(state_d);
   assign core_up  = (state_q == ST_RUN) || (state_q == ST_LOAD);

   rst_soft_timer #(.CYC(SOFT_CYC)) u_tmr (
      .clk    (clk),
      .rst_i  (por_i),
      .load_i (enter && state_d == ST_SOFT),
      .run_i  (state_q == ST_SOFT),
      .zero_o (tmr_zero)
   );

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         state_q <= ST_HARD;
         full_q  <= 1'b1;
         ready_q <= 1'b0;
         pd_q    <= 1'b1;
      end else begin
         state_q <= state_d;
         if (enter && state_d == ST_LOAD) begin
            if (state_q == ST_BUS)                                  full_q <= 1'b0;
            else if (state_q == ST_HARD || state_q == ST_SOFT)      full_q <= 1'b1;
         end
         if (enter && nxt_rank >= 3'd2)                  ready_q <= 1'b0;
         else if (state_q == ST_LOAD && state_d == ST_RUN) ready_q <= 1'b1;
         if (enter && nxt_rank >= 3'd2)                  pd_q <= 1'b1;
         else if (phy_wake_i && core_up)                 pd_q <= 1'b0;
      end
   end

   rst_cfg_keep #(.W(CFG_W), .KEEP(KEEP_MASK)) u_cfg (
      .clk        (clk),
      .rst_i      (por_i),
      .we_i       (cfg_we_i && core_up),
      .wd_i       (cfg_wd_i),
      .clr_all_i  (enter && nxt_rank >= 3'd4),
      .clr_part_i (enter && nxt_rank >= 3'd1 && nxt_rank <= 3'd3),
      .q_o        (cfg_q_o)
   );

   assign core_rst_o    = (st_rank(state_q) != 3'd0);
   assign bif_rst_o     = (st_rank(state_q) >= 3'd3);
   assign disconnect_o  = (st_rank(state_q) >= 3'd3);
   assign soft_bit_o    = (state_q == ST_SOFT);
   assign reload_req_o  = (state_q == ST_LOAD) && mem_present_i;
   assign reload_full_o = full_q;
   assign phy_pd_o      = pd_q;
   assign ready_o       = ready_q;

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
   parameter int               CFG_W     = 8,
   parameter logic [CFG_W-1:0] KEEP_MASK = 8'hF0
) (
   input logic             clk,
   input logic             por_i,
   input logic             vbus_i,
   input logic             ext_rst_n_i,
   input logic             mem_present_i,
   input logic             core_rst_o,
   input logic             bif_rst_o,
   input logic             disconnect_o,
   input logic             soft_bit_o,
   input logic             reload_req_o,
   input logic             reload_full_o,
   input logic             phy_pd_o,
   input logic             ready_o,
   input logic [CFG_W-1:0] cfg_q_o
);

   a_r2_power_loss: assert property (@(posedge clk) disable iff (por_i)
      !vbus_i |=> core_rst_o && bif_rst_o && disconnect_o);

   a_r4_soft_scope: assert property (@(posedge clk) disable iff (por_i)
      soft_bit_o |-> bif_rst_o && disconnect_o && core_rst_o);

   a_r5_soft_full_reload: assert property (@(posedge clk) disable iff (por_i)
      $fell(soft_bit_o) && $past(vbus_i) && $past(ext_rst_n_i) && mem_present_i
      |-> reload_req_o && reload_full_o && !core_rst_o);

   a_r6_bif_within_core: assert property (@(posedge clk) disable iff (por_i)
      bif_rst_o |-> core_rst_o);

   a_r8_ready_after_load: assert property (@(posedge clk) disable iff (por_i)
      $rose(ready_o) |-> !core_rst_o && !reload_req_o);

   a_r10_pd_on_reset: assert property (@(posedge clk) disable iff (por_i)
      $rose(phy_pd_o) |-> core_rst_o);

   a_r11_soft_keeps_mask: assert property (@(posedge clk) disable iff (por_i)
      $rose(soft_bit_o) |-> (cfg_q_o & KEEP_MASK) == ($past(cfg_q_o) & KEEP_MASK));

endmodule

bind rst_seq_ctrl rst_seq_chk #(.CFG_W(CFG_W), .KEEP_MASK(KEEP_MASK)) u_chk (.*);

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;

   localparam int         SOFT_CYC = 500;
   localparam int         NVEC     = 10;
   // {vbus, ext_n, soft, bus, lite, exp core, exp bif, exp disc, exp soft bit, exp ready}
   localparam logic [9:0] VEC [NVEC] = '{
      10'b01000_11100, 10'b10000_11100, 10'b11100_11110, 10'b11010_10000,
      10'b11001_10001, 10'b11110_11110, 10'b11011_10000, 10'b10100_11100,
      10'b00100_11100, 10'b11101_11110
   };

   logic clk = 1'b0;
   logic por_i = 1'b1, ext_rst_n_i = 1'b1, vbus_i = 1'b1, soft_wr_i = 1'b0;
   logic bus_rst_i = 1'b0, lite_req_i = 1'b0, mem_present_i = 1'b1, load_done_i = 1'b0;
   logic phy_wake_i = 1'b0, cfg_we_i = 1'b0;
   logic [7:0] cfg_wd_i = '0, cfg_q_o;
   logic core_rst_o, bif_rst_o, disconnect_o, soft_bit_o, reload_req_o;
   logic reload_full_o, phy_pd_o, ready_o;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   rst_seq_ctrl dut (.*);

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic recover();
      load_done_i = 1'b1;
      for (int i = 0; i < 2000; i++) begin
         if (ready_o && !core_rst_o) break;
         step();
      end
      load_done_i = 1'b0;
   endtask

   task automatic wr_cfg(input logic [7:0] d);
      cfg_we_i = 1'b1; cfg_wd_i = d;
      step();
      cfg_we_i = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      int cnt;
      @(negedge clk); @(negedge clk);
      // R3 R10: state while power-on reset is held
      chk("R3 core in por", core_rst_o, 1);
      chk("R3 bif in por", bif_rst_o, 1);
      chk("R3 disc in por", disconnect_o, 1);
      chk("R3 ready in por", ready_o, 0);
      chk("R3 cfg in por", cfg_q_o, 0);
      chk("R10 pd in por", phy_pd_o, 1);
      por_i = 1'b0;
      step();
      chk("R3 core released", core_rst_o, 0);
      chk("R3 full reload", {reload_req_o, reload_full_o}, 2'b11);
      step(); step(); step();
      chk("R8 ready while loading", ready_o, 0);
      chk("R8 req held", reload_req_o, 1);
      load_done_i = 1'b1;
      step();
      load_done_i = 1'b0;
      chk("R8 ready after done", ready_o, 1);
      chk("R8 req dropped", reload_req_o, 0);
      phy_wake_i = 1'b1; step(); phy_wake_i = 1'b0;
      chk("R10 wake clears pd", phy_pd_o, 0);

      // R1: table of single and overlapping requests, applied from idle
      for (int v = 0; v < NVEC; v++) begin
         {vbus_i, ext_rst_n_i, soft_wr_i, bus_rst_i, lite_req_i} = VEC[v][9:5];
         step();
         chk($sformatf("R1 vec%0d outputs", v),
             {core_rst_o, bif_rst_o, disconnect_o, soft_bit_o, ready_o}, VEC[v][4:0]);
         {vbus_i, ext_rst_n_i, soft_wr_i, bus_rst_i, lite_req_i} = 5'b11000;
         recover();
      end

      // R7 R10: lite reset
      phy_wake_i = 1'b1; step(); phy_wake_i = 1'b0;
      lite_req_i = 1'b1; step(); lite_req_i = 1'b0;
      chk("R7 core in lite", core_rst_o, 1);
      chk("R7 bif in lite", bif_rst_o, 0);
      chk("R7 pd untouched", phy_pd_o, 0);
      step();
      chk("R7 one cycle", core_rst_o, 0);
      chk("R7 no reload", reload_req_o, 0);
      chk("R7 ready kept", ready_o, 1);

      // R4 R5: soft reset length and completion
      soft_wr_i = 1'b1; step(); soft_wr_i = 1'b0;
      cnt = 0;
      while (soft_bit_o && cnt < 2000) begin
         chk("R4 soft scope", {core_rst_o, bif_rst_o, disconnect_o}, 3'b111);
         cnt++;
         step();
      end
      chk("R4 soft cycles", cnt, SOFT_CYC);
      chk("R5 soft full reload", {core_rst_o, reload_req_o, reload_full_o}, 3'b011);
      chk("R10 pd after soft", phy_pd_o, 1);
      recover();

      // R6: bus reset held for three cycles
      bus_rst_i = 1'b1;
      step(); step(); step();
      chk("R6 bus scope", {core_rst_o, bif_rst_o, disconnect_o}, 3'b100);
      bus_rst_i = 1'b0;
      step();
      chk("R6 partial reload", {core_rst_o, reload_req_o, reload_full_o, ready_o}, 4'b0100);
      recover();

      // R9: no configuration memory
      mem_present_i = 1'b0;
      bus_rst_i = 1'b1; step(); bus_rst_i = 1'b0;
      step();
      chk("R9 released", {core_rst_o, reload_req_o, ready_o}, 3'b000);
      step();
      chk("R9 ready next cycle", {reload_req_o, ready_o}, 2'b01);
      mem_present_i = 1'b1;

      // R2: power loss and return
      vbus_i = 1'b0; step(); step(); step();
      chk("R2 unpowered", {core_rst_o, bif_rst_o, disconnect_o}, 3'b111);
      vbus_i = 1'b1;
      step();
      chk("R2 board reset step", core_rst_o, 1);
      step();
      chk("R2 full reload", {core_rst_o, reload_req_o, reload_full_o}, 3'b011);
      recover();

      // R3: board reset
      ext_rst_n_i = 1'b0; step(); step();
      ext_rst_n_i = 1'b1;
      step();
      chk("R3 ext full reload", {core_rst_o, reload_req_o, reload_full_o}, 3'b011);
      recover();

      // R11: kept bits across resets
      wr_cfg(8'hFF);
      chk("R11 write", cfg_q_o, 8'hFF);
      soft_wr_i = 1'b1; step(); soft_wr_i = 1'b0;
      chk("R11 soft keeps mask", cfg_q_o, 8'hF0);
      recover();
      wr_cfg(8'hFF);
      bus_rst_i = 1'b1; step(); bus_rst_i = 1'b0;
      chk("R11 bus keeps mask", cfg_q_o, 8'hF0);
      recover();
      wr_cfg(8'hFF);
      lite_req_i = 1'b1; step(); lite_req_i = 1'b0;
      chk("R11 lite keeps mask", cfg_q_o, 8'hF0);
      recover();
      wr_cfg(8'hFF);
      ext_rst_n_i = 1'b0; step();
      chk("R11 board clears all", cfg_q_o, 8'h00);
      wr_cfg(8'hAA);
      chk("R11 write ignored in reset", cfg_q_o, 8'h00);
      ext_rst_n_i = 1'b1;
      recover();

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule